// File: doc/BRIEF.md
# Serial EEPROM Slave with Page Write Buffer

This block is the two-wire (I2C) slave side of a 256-byte nonvolatile store, modelled with a register array. The serial clock and data lines are oversampled on the system clock. START, STOP and repeated START conditions are detected from the synchronised lines. The slave answers one fixed 7-bit device address and drives SDA through an open-drain style enable: when the enable is high the pin is pulled low.

A write sends a control byte, then a word address that loads the internal pointer, then data bytes. The data bytes are collected in an eight-entry buffer that wraps inside one aligned page. A STOP commits the buffer through a self-timed write cycle. While that cycle runs, the slave acknowledges nothing, so a master can poll for completion by sending its address. Reads come in three forms: from the current pointer, at a random address set by a dummy write and a repeated START, or sequentially while the master keeps acknowledging.

Writes are gated by three things: a clock-enable level input, an active-low protect input, and a sticky fuse. The fuse is set the first time a byte is committed to address 7Fh. After that, the protect input can lock the lower half of the array.

Top module: `i2c_eeprom_slave`

## Requirements
- R1: The slave acknowledges a control byte only when its upper seven bits equal the DEV_ADDR parameter (default 1010000b). Bit 0 selects read (1) or write (0). Any other address is not acknowledged, and the slave then ignores the bus until the next START.
- R2: In a write, the byte after the control byte loads the address pointer. Each data byte after that is acknowledged on the ninth clock.
- R3: After each data byte, only the low three pointer bits advance. The upper five bits stay fixed, so a ninth or later byte wraps within the eight-byte page and replaces the earlier buffered byte in that slot.
- R4: A STOP that follows at least one data byte starts a write cycle lasting WR_CYCLES clocks. Until the cycle ends, no byte is acknowledged, not even the slave's own address.
- R5: The commit is cancelled if the VCLK level input is low at any time between START and STOP. A change on that input during the write cycle has no effect on the commit.
- R6: Committing any byte to address 7Fh sets a fuse that never clears. While the fuse is clear, the protect input is ignored.
- R7: Once the fuse is set, a write is cancelled if the protect input is low at any time between START and STOP and the page lies in 00h–7Fh. Pages in 80h–FFh are not affected by the protect input.
- R8: A read with no address phase (current-address read) returns the byte at the location after the last one accessed.
- R9: A write carrying only a word address, followed by a repeated START and a read control byte, returns the byte at that word address.
- R10: In a read, a master ACK makes the slave send the next byte, and the pointer wraps from FFh to 00h. A master NACK followed by STOP leaves SDA released.
- R11: A commit writes only the page slots that received bytes. The other locations in the page keep their contents.
- R12: After reset SDA is released. The slave changes its SDA drive only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level (wired bus value) |
| sda_pull_o | output | 1 | High pulls SDA low (open-drain enable) |
| vclk_i | input | 1 | Write-enable level; low blocks all writes |
| wp_n_i | input | 1 | Active-low protect for 00h–7Fh once the fuse is set |

## Verification
The bench builds the slave with WR_CYCLES = 600 and the default eight-byte page. With this setting, the first acknowledge poll after a STOP falls inside the write cycle and must be refused, and a later poll must succeed. The short cycle also keeps the many write-then-read sequences within budget. These sequences include a ten-byte page wrap, a partial page overwrite, an FFh-to-00h sequential read, and write gating by the VCLK level, the fuse and the protect input.

// File: rtl/i2c_ee_pkg.sv
package i2c_ee_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [3:0] {
    PH_IDLE,
    PH_CTL,
    PH_CTL_ACK,
    PH_WADR,
    PH_WADR_ACK,
    PH_WDAT,
    PH_WDAT_ACK,
    PH_TX,
    PH_TX_ACK
  } bus_ph_e;
endpackage

// File: rtl/i2c_line_cond.sv
module i2c_line_cond #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  input  logic vclk_i,
  input  logic wp_n_i,
  output logic scl_o,
  output logic sda_o,
  output logic vclk_o,
  output logic wp_n_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  localparam int CW = SYNC_STAGES * 4;

  logic [CW-1:0] chain_q;
  logic          scl_d_q, sda_d_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '1;
      scl_d_q <= 1'b1;
      sda_d_q <= 1'b1;
    end else begin
      chain_q <= {chain_q[CW-5:0], scl_i, sda_i, vclk_i, wp_n_i};
      scl_d_q <= chain_q[CW-1];
      sda_d_q <= chain_q[CW-2];
    end
  end

  assign scl_o      = chain_q[CW-1];
  assign sda_o      = chain_q[CW-2];
  assign vclk_o     = chain_q[CW-3];
  assign wp_n_o     = chain_q[CW-4];
  assign scl_rise_o = scl_o & ~scl_d_q;
  assign scl_fall_o = ~scl_o & scl_d_q;
  assign start_o    = scl_o & scl_d_q & sda_d_q & ~sda_o;
  assign stop_o     = scl_o & scl_d_q & ~sda_d_q & sda_o;
endmodule

// File: rtl/ee_page_buf.sv
module ee_page_buf #(
  parameter int SLOTS = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       clr_i,
  input  logic                       we_i,
  input  logic [$clog2(SLOTS)-1:0]   slot_i,
  input  logic [7:0]                 data_i,
  output logic [SLOTS-1:0]           valid_o,
  output logic [SLOTS*8-1:0]         data_o
);
  localparam int SW = $clog2(SLOTS);

  logic [SLOTS-1:0] valid_q;

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    logic [7:0] byte_q;
    logic       hit;
    assign hit = we_i && (slot_i == SW'(g));

    always_ff @(posedge clk) begin
      if (hit) byte_q <= data_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     valid_q[g] <= 1'b0;
      else if (clr_i) valid_q[g] <= 1'b0;
      else if (hit)   valid_q[g] <= 1'b1;
    end

    assign data_o[g*8 +: 8] = byte_q;
  end

  assign valid_o = valid_q;

  AST_CLR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    $past(clr_i) |-> (valid_q == '0)); // R11
endmodule

// File: rtl/i2c_eeprom_slave.sv
module i2c_eeprom_slave
  import i2c_ee_pkg::*;
#(
  parameter int         PAGE_BYTES  = 8,
  parameter int         WR_CYCLES   = 50000,
  parameter logic [6:0] DEV_ADDR    = 7'b1010000,
  parameter logic [7:0] FUSE_ADDR   = 8'h7F,
  parameter int         SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_pull_o,
  input  logic vclk_i,
  input  logic wp_n_i
);
  localparam int SW    = $clog2(PAGE_BYTES);
  localparam int PG_HI = BYTE_W - SW;
  localparam int CNT_W = $clog2(WR_CYCLES + 1);
  localparam int DEPTH = 1 << BYTE_W;

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_ni;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ni = rst_sync_q[1];

  logic scl_s, sda_s, vclk_s, wp_n_s, scl_rise, scl_fall, start_det, stop_det;

  i2c_line_cond #(.SYNC_STAGES(SYNC_STAGES)) u_lines (
    .clk(clk), .rst_n(rst_ni), .scl_i(scl_i), .sda_i(sda_i),
    .vclk_i(vclk_i), .wp_n_i(wp_n_i), .scl_o(scl_s), .sda_o(sda_s),
    .vclk_o(vclk_s), .wp_n_o(wp_n_s), .scl_rise_o(scl_rise),
    .scl_fall_o(scl_fall), .start_o(start_det), .stop_o(stop_det)
  );

  logic                    pb_we;
  logic [PAGE_BYTES-1:0]   pb_valid;
  logic [PAGE_BYTES*8-1:0] pb_data;
  logic [7:0]              sh_q, sh_n;

  ee_page_buf #(.SLOTS(PAGE_BYTES)) u_pbuf (
    .clk(clk), .rst_n(rst_ni), .clr_i(start_det), .we_i(pb_we),
    .slot_i(ptr_q[SW-1:0]), .data_i(sh_q), .valid_o(pb_valid), .data_o(pb_data)
  );

  bus_ph_e               st_q, st_n;
  logic [3:0]            cnt_q, cnt_n;
  logic [7:0]            ptr_q, ptr_n;
  logic                  rw_q, rw_n, oe_q, oe_n, mack_q, mack_n;
  logic                  busy_q, busy_n, vlo_q, vlo_n, wlo_q, wlo_n, cok_q, cok_n;
  logic [CNT_W-1:0]      wcnt_q, wcnt_n;
  logic [PAGE_BYTES-1:0] cmask_q, cmask_n;
  logic [PG_HI-1:0]      cpage_q, cpage_n;
  logic                  fuse_q, commit, fuse_set;
  logic [7:0]            mem_q [DEPTH];
  logic [7:0]            rd_byte;

  assign rd_byte  = mem_q[ptr_q];
  assign commit   = busy_q && (wcnt_q == '0);
  assign fuse_set = commit && cok_q && cmask_q[FUSE_ADDR[SW-1:0]]
                    && (cpage_q == FUSE_ADDR[BYTE_W-1:SW]);

  always_comb begin
    st_n = st_q; cnt_n = cnt_q; sh_n = sh_q; ptr_n = ptr_q; rw_n = rw_q;
    oe_n = oe_q; mack_n = mack_q; busy_n = busy_q; wcnt_n = wcnt_q;
    vlo_n = vlo_q | ~vclk_s; wlo_n = wlo_q | ~wp_n_s;
    cmask_n = cmask_q; cpage_n = cpage_q; cok_n = cok_q; pb_we = 1'b0;

    if (busy_q) begin
      if (wcnt_q == '0) busy_n = 1'b0;
      else              wcnt_n = wcnt_q - 1'b1;
    end

    if (start_det) begin
      st_n = PH_CTL; cnt_n = '0; oe_n = 1'b0;
      vlo_n = ~vclk_s; wlo_n = ~wp_n_s;
    end else if (stop_det) begin
      st_n = PH_IDLE; oe_n = 1'b0;
      if ((st_q == PH_WDAT) && (|pb_valid) && !busy_q) begin
        busy_n  = 1'b1;
        wcnt_n  = CNT_W'(WR_CYCLES - 1);
        cmask_n = pb_valid;
        cpage_n = ptr_q[BYTE_W-1:SW];
        cok_n   = !vlo_q && !(fuse_q && wlo_q && !ptr_q[BYTE_W-1]);
      end
    end else begin
      unique case (st_q)
        PH_CTL, PH_WADR, PH_WDAT: begin
          if (scl_rise && cnt_q < 4'd8) begin
            sh_n  = {sh_q[6:0], sda_s};
            cnt_n = cnt_q + 4'd1;
          end
          if (scl_fall && cnt_q == 4'd8) begin
            oe_n = 1'b1;
            if (st_q == PH_CTL) begin
              if (sh_q[7:1] == DEV_ADDR && !busy_q) begin
                rw_n = sh_q[0]; st_n = PH_CTL_ACK;
              end else begin
                oe_n = 1'b0; st_n = PH_IDLE;
              end
            end else if (st_q == PH_WADR) begin
              ptr_n = sh_q; st_n = PH_WADR_ACK;
            end else begin
              pb_we = 1'b1;
              ptr_n = {ptr_q[BYTE_W-1:SW], ptr_q[SW-1:0] + 1'b1};
              st_n  = PH_WDAT_ACK;
            end
          end
        end
        PH_CTL_ACK, PH_WADR_ACK, PH_WDAT_ACK: begin
          if (scl_fall) begin
            cnt_n = '0;
            oe_n  = 1'b0;
            if (st_q == PH_CTL_ACK && rw_q) begin
              st_n = PH_TX; sh_n = rd_byte; oe_n = ~rd_byte[7];
            end else begin
              st_n = (st_q == PH_CTL_ACK) ? PH_WADR : PH_WDAT;
            end
          end
        end
        PH_TX: begin
          if (scl_fall) begin
            if (cnt_q == 4'd7) begin
              st_n = PH_TX_ACK; oe_n = 1'b0; ptr_n = ptr_q + 8'd1;
            end else begin
              sh_n = {sh_q[6:0], 1'b0}; cnt_n = cnt_q + 4'd1; oe_n = ~sh_q[6];
            end
          end
        end
        PH_TX_ACK: begin
          if (scl_rise) mack_n = ~sda_s;
          if (scl_fall) begin
            if (mack_q) begin
              st_n = PH_TX; sh_n = rd_byte; oe_n = ~rd_byte[7]; cnt_n = '0;
            end else begin
              st_n = PH_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= PH_IDLE; cnt_q <= '0; sh_q <= '0; ptr_q <= '0; rw_q <= 1'b0;
      oe_q <= 1'b0; mack_q <= 1'b0; busy_q <= 1'b0; wcnt_q <= '0;
      vlo_q <= 1'b0; wlo_q <= 1'b0; cmask_q <= '0; cpage_q <= '0; cok_q <= 1'b0;
      fuse_q <= 1'b0;
    end else begin
      st_q <= st_n; cnt_q <= cnt_n; sh_q <= sh_n; ptr_q <= ptr_n; rw_q <= rw_n;
      oe_q <= oe_n; mack_q <= mack_n; busy_q <= busy_n; wcnt_q <= wcnt_n;
      vlo_q <= vlo_n; wlo_q <= wlo_n; cmask_q <= cmask_n; cpage_q <= cpage_n;
      cok_q <= cok_n;
      if (fuse_set) fuse_q <= 1'b1;
    end
  end

  // array commit at the end of the self-timed cycle
  always_ff @(posedge clk) begin
    if (commit && cok_q) begin
      for (int i = 0; i < PAGE_BYTES; i++) begin
        if (cmask_q[i]) mem_q[{cpage_q, SW'(i)}] <= pb_data[i*8 +: 8];
      end
    end
  end

  assign sda_pull_o = oe_q;

  AST_SDA_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_ni)
    !$stable(oe_q) |-> !scl_s); // R12
  AST_BUSY_FROM_STOP: assert property (@(posedge clk) disable iff (!rst_ni)
    $rose(busy_q) |-> $past(stop_det)); // R4
  AST_PAGE_HOLD: assert property (@(posedge clk) disable iff (!rst_ni)
    (st_q == PH_WDAT_ACK && $past(st_q) == PH_WDAT)
      |-> (ptr_q[BYTE_W-1:SW] == $past(ptr_q[BYTE_W-1:SW]))); // R3
  AST_FUSE_STICKY: assert property (@(posedge clk) disable iff (!rst_ni)
    $past(fuse_q) |-> fuse_q); // R6
endmodule

// File: tb/sim_i2c_eeprom_slave.sv
module sim_i2c_eeprom_slave;
  localparam int CLK_PERIOD = 10;
  localparam int Q          = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1, vclk = 1'b1, wp_n = 1'b1;
  logic sda_pull, sda_line;
  int   checks = 0, errors = 0;
  bit   done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign sda_line = sda_m & ~sda_pull;

  i2c_eeprom_slave #(.WR_CYCLES(600)) u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .sda_pull_o(sda_pull), .vclk_i(vclk), .wp_n_i(wp_n)
  );

  string      tag_q[$];
  logic [7:0] val_q[$];
  logic [7:0] obs_byte;
  event       obs_ev;
  logic [7:0] wbuf [16];
  logic [7:0] ebuf [16];

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // scoreboard monitor: pops expectations as read bytes arrive
  always begin
    string t;
    logic [7:0] v;
    @(obs_ev);
    checks++;
    if (val_q.size() == 0) begin
      errors++;
      $display("FAIL R10: actual %0h expected none (unexpected byte)", obs_byte);
    end else begin
      t = tag_q.pop_front();
      v = val_q.pop_front();
      if (obs_byte !== v) begin
        errors++;
        $display("FAIL %s: actual %0h expected %0h", t, obs_byte, v);
      end
    end
  end

  task automatic hold(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic put_bit(input logic b);
    sda_m = b; hold(Q); scl_m = 1'b1; hold(2*Q); scl_m = 1'b0; hold(Q);
  endtask

  task automatic get_bit(output logic b);
    sda_m = 1'b1; hold(Q); scl_m = 1'b1; hold(Q); b = sda_line; hold(Q);
    scl_m = 1'b0; hold(Q);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; hold(Q); scl_m = 1'b1; hold(Q); sda_m = 1'b0; hold(Q);
    scl_m = 1'b0; hold(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; hold(Q); scl_m = 1'b1; hold(Q); sda_m = 1'b1; hold(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic nack);
    for (int i = 7; i >= 0; i--) put_bit(b[i]);
    get_bit(nack);
  endtask

  task automatic recv_byte(output logic [7:0] b, input bit ack);
    logic x;
    for (int i = 7; i >= 0; i--) begin
      get_bit(x);
      b[i] = x;
    end
    put_bit(ack ? 1'b0 : 1'b1);
  endtask

  task automatic wr(input string tag, input logic [7:0] addr, input int n);
    logic nk;
    bus_start();
    send_byte(8'hA0, nk); chk({tag, " ctl ack"}, nk, 0);
    send_byte(addr, nk);  chk({tag, " addr ack"}, nk, 0);
    for (int i = 0; i < n; i++) begin
      send_byte(wbuf[i], nk); chk({tag, " data ack"}, nk, 0);
    end
    bus_stop();
  endtask

  task automatic poll(output int tries);
    logic nk;
    tries = 0;
    for (int k = 0; k < 60; k++) begin
      bus_start();
      send_byte(8'hA0, nk);
      bus_stop();
      tries++;
      if (nk == 1'b0) break;
      hold(64);
    end
  endtask

  task automatic rd(input string tag, input bit random, input logic [7:0] addr, input int n);
    logic nk;
    logic [7:0] b;
    for (int i = 0; i < n; i++) begin
      tag_q.push_back(tag);
      val_q.push_back(ebuf[i]);
    end
    bus_start();
    if (random) begin
      send_byte(8'hA0, nk); chk({tag, " dummy ctl ack"}, nk, 0);
      send_byte(addr, nk);  chk({tag, " dummy addr ack"}, nk, 0);
      bus_start();
    end
    send_byte(8'hA1, nk); chk({tag, " read ctl ack"}, nk, 0);
    for (int i = 0; i < n; i++) begin
      recv_byte(b, i != n - 1);
      obs_byte = b;
      -> obs_ev;
    end
    bus_stop();
    hold(Q);
    chk("R10 SDA released after NACK+STOP", sda_pull, 0);
  endtask

  task automatic wr1_poll(input string tag, input logic [7:0] addr, input logic [7:0] d);
    int t;
    wbuf[0] = d;
    wr(tag, addr, 1);
    poll(t);
  endtask

  task automatic rd1(input string tag, input logic [7:0] addr, input logic [7:0] e);
    ebuf[0] = e;
    rd(tag, 1'b1, addr, 1);
  endtask

  initial begin
    logic nk;
    int   tries;
    hold(5);
    chk("R12 SDA released in reset", sda_pull, 0);
    rst_n = 1'b1;
    hold(10);
    chk("R12 SDA released after reset", sda_pull, 0);

    // R1: foreign address, then a byte without START
    bus_start();
    send_byte(8'hA2, nk); chk("R1 foreign address NACK", nk, 1);
    send_byte(8'hA0, nk); chk("R1 ignored until next START", nk, 1);
    bus_stop();
    hold(20);

    // R2/R4/R9: byte write, poll, random read
    wbuf[0] = 8'h5E;
    wr("R2 byte write", 8'h10, 1);
    poll(tries);
    chk("R4 first poll refused during write cycle", tries > 1, 1);
    chk("R4 poll ends acknowledged", tries < 60, 1);
    rd1("R9 random read 10h", 8'h10, 8'h5E);

    // R3: ten bytes from 22h wrap inside page 20h-27h
    for (int i = 0; i < 10; i++) wbuf[i] = 8'h80 + 8'(i);
    wr("R3 page write", 8'h22, 10);
    poll(tries);
    ebuf[0] = 8'h86; ebuf[1] = 8'h87; ebuf[2] = 8'h88; ebuf[3] = 8'h89;
    ebuf[4] = 8'h82; ebuf[5] = 8'h83; ebuf[6] = 8'h84; ebuf[7] = 8'h85;
    rd("R3 page wrap readback", 1'b1, 8'h20, 8);

    // R11: partial page leaves other slots intact
    for (int i = 0; i < 8; i++) wbuf[i] = 8'hA0 + 8'(i);
    wr("R11 full page", 8'h40, 8);
    poll(tries);
    wr1_poll("R11 single byte", 8'h45, 8'h55);
    for (int i = 0; i < 8; i++) ebuf[i] = 8'hA0 + 8'(i);
    ebuf[5] = 8'h55;
    rd("R11 partial commit readback", 1'b1, 8'h40, 8);

    // R8: current-address read after random read of 44h
    rd1("R8 random read 44h", 8'h44, 8'hA4);
    ebuf[0] = 8'h55;
    rd("R8 current-address read", 1'b0, 8'h00, 1);

    // R10: sequential read wraps FFh -> 00h
    wr1_poll("R10 prep 00h", 8'h00, 8'h3C);
    wr1_poll("R10 prep FFh", 8'hFF, 8'hF1);
    ebuf[0] = 8'hF1; ebuf[1] = 8'h3C;
    rd("R10 sequential wrap", 1'b1, 8'hFF, 2);

    // R5: VCLK low during transfer blocks; VCLK drop during cycle does not
    wr1_poll("R5 prep 60h", 8'h60, 8'h11);
    vclk = 1'b0;
    bus_start();
    send_byte(8'hA0, nk); chk("R5 ctl ack with VCLK low", nk, 0);
    vclk = 1'b1;
    send_byte(8'h60, nk);
    send_byte(8'h99, nk); chk("R5 data still acked", nk, 0);
    bus_stop();
    poll(tries);
    rd1("R5 VCLK low cancels write", 8'h60, 8'h11);
    wbuf[0] = 8'h77;
    wr("R5 write then VCLK drop", 8'h61, 1);
    vclk = 1'b0; hold(50); vclk = 1'b1;
    poll(tries);
    rd1("R5 VCLK drop in cycle ignored", 8'h61, 8'h77);

    // R6/R7: fuse and protect input
    wp_n = 1'b0;
    wbuf[0] = 8'h5A;
    wr("R6 write with WP low, fuse clear", 8'h50, 1);
    wp_n = 1'b1;
    poll(tries);
    rd1("R6 WP ignored before fuse", 8'h50, 8'h5A);
    wr1_poll("R6 fuse write 7Fh", 8'h7F, 8'hC3);
    rd1("R6 7Fh content", 8'h7F, 8'hC3);
    wp_n = 1'b0;
    wbuf[0] = 8'hA5;
    wr("R7 protected write", 8'h50, 1);
    poll(tries);
    rd1("R7 lower half locked", 8'h50, 8'h5A);
    wbuf[0] = 8'h12;
    wr("R7 upper half write", 8'h90, 1);
    poll(tries);
    rd1("R7 upper half writable", 8'h90, 8'h12);
    wp_n = 1'b1;
    wr1_poll("R6 fuse set, WP high", 8'h50, 8'hA5);
    rd1("R6 WP high allows write", 8'h50, 8'hA5);

    hold(20);
    chk("R10 scoreboard drained", val_q.size(), 0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule